// File: doc/BRIEF.md
# Priority Transmit Queue Selector

This block keeps the request state of a small group of transmit buffers and treats them as a priority queue. Every buffer has an identifier field, a flag that marks the identifier as extended (29 bits) or standard (11 bits), and a pending flag held inside the block. In every cycle the block names the pending buffer that should go out next. It also gives a put index that software uses to find a free buffer, and a full flag. The block holds no message storage and no bus protocol logic.

Software or a host engine raises requests with a per-buffer set vector and withdraws them with a per-buffer cancel vector. The transmitter returns a done pulse for whichever buffer is selected. The selection is combinational over the pending set and the identifier fields. Pending bits, and the pointer behind the put index, change on the clock edge that follows the stimulus.

Top module: `txq_prio_sel`

## Requirements
- R1: `sel_vld_o` is high exactly when at least one pending bit is set. While it is high, `sel_idx_o` names a pending buffer whose identifier has the highest priority, where a numerically lower identifier means a higher priority.
- R2: A standard identifier is held in bits 10:0 of its buffer's identifier field, and bits 28:11 of that field are ignored. When a standard buffer is compared with an extended buffer, the 11 standard bits are compared against bits 28:18 of the extended identifier.
- R3: When a standard identifier equals bits 28:18 of an extended identifier, the standard buffer is selected.
- R4: Two extended identifiers are compared on all 29 bits.
- R5: When pending buffers have equal priority, the buffer with the lowest number is selected.
- R6: A set bit in `req_set_i` makes that buffer pending at the next clock edge. Setting a buffer that is already pending has no effect.
- R7: A set bit in `cancel_i` clears that buffer's pending bit at the next clock edge. If set and cancel hit the same buffer in the same cycle, cancel wins.
- R8: When `tx_done_i` is high while `sel_vld_o` is high, the selected buffer's pending bit clears at the next clock edge. When `sel_vld_o` is low, `tx_done_i` is ignored.
- R9: `full_o` is high exactly when every buffer is pending. In that state `put_idx_o` reads 0 and is not valid. Otherwise `put_idx_o` names a buffer that is not pending.
- R10: `put_idx_o` is the first non-pending buffer found by a cyclic search that starts at an internal pointer. A request set on the buffer named by `put_idx_o` while `full_o` is low moves the pointer to the next buffer in cyclic order.
- R11: `full_o` falls in the cycle after any pending request is transmitted or cancelled.
- R12: After reset, no buffer is pending, `sel_vld_o` and `full_o` are low, and `put_idx_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_set_i | input | NUM_BUF | Per-buffer request set |
| cancel_i | input | NUM_BUF | Per-buffer request cancel |
| tx_done_i | input | 1 | Transmission of the selected buffer finished |
| buf_id_i | input | NUM_BUF*ID_W | Identifier fields; buffer k occupies bits k*ID_W +: ID_W |
| buf_xtd_i | input | NUM_BUF | 1 = the buffer's identifier is extended |
| sel_idx_o | output | IDX_W | Buffer chosen for transmission |
| sel_vld_o | output | 1 | A buffer is chosen |
| put_idx_o | output | IDX_W | Free buffer for the next add request |
| full_o | output | 1 | Every buffer is pending |
| pend_o | output | NUM_BUF | Pending vector |

## Verification
Two situations are hard to reach. The first is a selection decided only by the format rule, where a standard identifier equals the top bits of an extended one. The second is a pointer wrap while the queue is almost full. Random identifiers drawn from a pool of only four base values make both situations frequent. Standard entries also carry random garbage in their unused upper bits. Directed steps force the exact collisions: standard against extended with an equal base, extended against extended with equal top bits, identical identifiers, and set together with cancel on the same buffer. Other directed steps fill the queue through the put index and then free it with a done pulse or a cancel.

// File: rtl/txq_pkg.sv
package txq_pkg;

   // Cyclic successor of an index within a set of n entries
   function automatic int unsigned wrap_next(int unsigned cur, int unsigned n);
      return (cur + 1 >= n) ? 0 : cur + 1;
   endfunction

   // Width of a priority key: base, format bit, extension bits
   function automatic int unsigned key_width(int unsigned id_w, int unsigned std_w);
      return std_w + 1 + (id_w - std_w);
   endfunction

endpackage

// File: rtl/txq_key_build.sv
module txq_key_build #(
   parameter int unsigned ID_W  = 29,
   parameter int unsigned STD_W = 11,
   parameter int unsigned KEY_W = txq_pkg::key_width(ID_W, STD_W)
) (
   input  logic [ID_W-1:0]  id_i,
   input  logic             xtd_i,
   output logic [KEY_W-1:0] key_o
);
   localparam int unsigned EXT_W = ID_W - STD_W;

   initial begin
      if (STD_W == 0 || STD_W > ID_W)
         $error("txq_key_build: STD_W must lie in 1..ID_W");
      if (KEY_W != STD_W + 1 + EXT_W)
         $error("txq_key_build: KEY_W mismatch");
   end

   logic [STD_W-1:0] base;
   logic [EXT_W-1:0] ext;

   generate
      if (EXT_W > 0) begin : g_ext
         always_comb begin
            base = xtd_i ? id_i[ID_W-1 -: STD_W] : id_i[STD_W-1:0];
            ext  = xtd_i ? id_i[EXT_W-1:0] : '0;
         end
      end else begin : g_std_only
         always_comb begin
            base = id_i[STD_W-1:0];
            ext  = '0;
         end
      end
   endgenerate

   // Standard format bit 0 sorts ahead of extended on equal base
   assign key_o = {base, xtd_i, ext};
endmodule

// File: rtl/txq_prio_arb.sv
module txq_prio_arb #(
   parameter int unsigned NUM_BUF = 3,
   parameter int unsigned KEY_W   = 30,
   parameter int unsigned IDX_W   = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
   input  logic [NUM_BUF-1:0]       vld_i,
   input  logic [NUM_BUF*KEY_W-1:0] key_i,
   output logic [IDX_W-1:0]         idx_o,
   output logic                     any_o
);
   initial begin
      if (NUM_BUF < 2) $error("txq_prio_arb: NUM_BUF must be at least 2");
   end

   // Linear chain: stage k holds the winner among buffers 0..k
   logic [KEY_W-1:0] st_key [NUM_BUF];
   logic [IDX_W-1:0] st_idx [NUM_BUF];
   logic             st_vld [NUM_BUF];

   generate
      for (genvar k = 0; k < NUM_BUF; k++) begin : g_stage
         logic [KEY_W-1:0] my_key;
         assign my_key = key_i[k*KEY_W +: KEY_W];
         if (k == 0) begin : g_first
            assign st_key[k] = my_key;
            assign st_idx[k] = '0;
            assign st_vld[k] = vld_i[k];
         end else begin : g_next
            logic take;
            // Strict less keeps the lower-numbered buffer on ties
            assign take = vld_i[k] && (!st_vld[k-1] || (my_key < st_key[k-1]));
            assign st_key[k] = take ? my_key : st_key[k-1];
            assign st_idx[k] = take ? IDX_W'(k) : st_idx[k-1];
            assign st_vld[k] = st_vld[k-1] | vld_i[k];
         end
      end
   endgenerate

   assign idx_o = st_vld[NUM_BUF-1] ? st_idx[NUM_BUF-1] : '0;
   assign any_o = st_vld[NUM_BUF-1];
endmodule

// File: rtl/txq_put_ptr.sv
module txq_put_ptr #(
   parameter int unsigned NUM_BUF = 3,
   parameter int unsigned IDX_W   = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_BUF-1:0] pend_i,
   input  logic [NUM_BUF-1:0] req_set_i,
   output logic [IDX_W-1:0]   put_o,
   output logic               full_o
);
   initial begin
      if (NUM_BUF < 2) $error("txq_put_ptr: NUM_BUF must be at least 2");
   end

   logic [IDX_W-1:0] ptr_q;
   logic [IDX_W-1:0] free_idx;
   logic             found;
   logic [IDX_W:0]   cand;

   // Cyclic search for the first free buffer at or after the pointer
   always_comb begin
      free_idx = '0;
      found    = 1'b0;
      cand     = '0;
      for (int o = 0; o < NUM_BUF; o++) begin
         cand = {1'b0, ptr_q} + (IDX_W+1)'(o);
         if (cand >= (IDX_W+1)'(NUM_BUF)) cand = cand - (IDX_W+1)'(NUM_BUF);
         if (!found && !pend_i[cand[IDX_W-1:0]]) begin
            found    = 1'b1;
            free_idx = cand[IDX_W-1:0];
         end
      end
   end

   assign full_o = &pend_i;
   assign put_o  = full_o ? '0 : free_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (!full_o && req_set_i[free_idx]) begin
         ptr_q <= IDX_W'(txq_pkg::wrap_next(32'(free_idx), NUM_BUF));
      end
   end

   p_ptr_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q < IDX_W'(NUM_BUF));

   p_put_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !full_o |-> !pend_i[put_o]);

   p_full_put_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      full_o |-> (put_o == '0));
endmodule

// File: rtl/txq_prio_sel.sv
module txq_prio_sel #(
   parameter int unsigned NUM_BUF = 3,
   parameter int unsigned ID_W    = 29,
   parameter int unsigned STD_W   = 11,
   parameter int unsigned IDX_W   = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_BUF-1:0]      req_set_i,
   input  logic [NUM_BUF-1:0]      cancel_i,
   input  logic                    tx_done_i,
   input  logic [NUM_BUF*ID_W-1:0] buf_id_i,
   input  logic [NUM_BUF-1:0]      buf_xtd_i,
   output logic [IDX_W-1:0]        sel_idx_o,
   output logic                    sel_vld_o,
   output logic [IDX_W-1:0]        put_idx_o,
   output logic                    full_o,
   output logic [NUM_BUF-1:0]      pend_o
);
   localparam int unsigned KEY_W = txq_pkg::key_width(ID_W, STD_W);

   initial begin
      if (NUM_BUF < 2) $error("txq_prio_sel: NUM_BUF must be at least 2");
      if (IDX_W < $clog2(NUM_BUF)) $error("txq_prio_sel: IDX_W too narrow");
   end

   logic [NUM_BUF-1:0]       pend_q;
   logic [NUM_BUF-1:0]       pend_d;
   logic [NUM_BUF*KEY_W-1:0] key_flat;
   logic [KEY_W-1:0]         key_a [NUM_BUF];
   logic                     done_eff;

   generate
      for (genvar k = 0; k < NUM_BUF; k++) begin : g_buf
         txq_key_build #(.ID_W(ID_W), .STD_W(STD_W), .KEY_W(KEY_W)) u_key (
            .id_i  (buf_id_i[k*ID_W +: ID_W]),
            .xtd_i (buf_xtd_i[k]),
            .key_o (key_a[k])
         );
         assign key_flat[k*KEY_W +: KEY_W] = key_a[k];

         // Cancel and completion dominate a same-cycle set
         assign pend_d[k] = (pend_q[k] | req_set_i[k]) & ~cancel_i[k]
                            & ~(done_eff && (sel_idx_o == IDX_W'(k)));

         p_cancel_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
            cancel_i[k] |=> !pend_q[k]);

         p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (req_set_i[k] && !cancel_i[k]
             && !(tx_done_i && sel_vld_o && sel_idx_o == IDX_W'(k))) |=> pend_q[k]);

         p_min_key_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_vld_o && pend_q[k]) |-> (key_a[sel_idx_o] <= key_a[k]));

         p_tie_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_vld_o && pend_q[k] && key_a[sel_idx_o] == key_a[k])
            |-> (sel_idx_o <= IDX_W'(k)));
      end
   endgenerate

   txq_prio_arb #(.NUM_BUF(NUM_BUF), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_arb (
      .vld_i (pend_q),
      .key_i (key_flat),
      .idx_o (sel_idx_o),
      .any_o (sel_vld_o)
   );

   txq_put_ptr #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) u_put (
      .clk       (clk),
      .rst_n     (rst_n),
      .pend_i    (pend_q),
      .req_set_i (req_set_i),
      .put_o     (put_idx_o),
      .full_o    (full_o)
   );

   assign done_eff = tx_done_i && sel_vld_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_d;
   end

   assign pend_o = pend_q;

   p_vld_any_r1: assert property (@(posedge clk) disable iff (!rst_n)
      sel_vld_o == (|pend_q));

   p_sel_pending_r1: assert property (@(posedge clk) disable iff (!rst_n)
      sel_vld_o |-> pend_q[sel_idx_o]);

   p_done_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_done_i && sel_vld_o) |=> !pend_q[$past(sel_idx_o)]);

   p_full_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
      full_o == (&pend_q));

   p_full_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && (|cancel_i || tx_done_i)) |=> !full_o);
endmodule

// File: tb/txq_prio_sel_bench.sv
module txq_prio_sel_bench;
   localparam int NB = 3;
   localparam int IW = 29;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NB-1:0] req_set = '0;
   logic [NB-1:0] cancel = '0;
   logic          done = 1'b0;
   logic [IW-1:0] bid [NB];
   logic [NB-1:0] bx = '0;
   logic [1:0]    sel_idx, put_idx;
   logic          sel_vld, full;
   logic [NB-1:0] pend;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   logic [NB-1:0] m_pend;
   int            m_ptr;

   always #5 clk = ~clk;

   txq_prio_sel u_txq_prio_sel (
      .clk(clk), .rst_n(rst_n), .req_set_i(req_set), .cancel_i(cancel),
      .tx_done_i(done), .buf_id_i({bid[2], bid[1], bid[0]}), .buf_xtd_i(bx),
      .sel_idx_o(sel_idx), .sel_vld_o(sel_vld), .put_idx_o(put_idx),
      .full_o(full), .pend_o(pend)
   );

   function automatic int base_of(int i);
      return bx[i] ? int'(bid[i][28:18]) : int'(bid[i][10:0]);
   endfunction

   // True when buffer a strictly outranks buffer b
   function automatic bit beats(int a, int b);
      if (base_of(a) != base_of(b)) return base_of(a) < base_of(b);
      if (bx[a] != bx[b]) return !bx[a];
      if (bx[a]) return bid[a] < bid[b];
      return 1'b0;
   endfunction

   function automatic int exp_sel(logic [NB-1:0] p);
      int best = -1;
      for (int i = 0; i < NB; i++)
         if (p[i] && (best < 0 || beats(i, best))) best = i;
      return best;
   endfunction

   function automatic int exp_put(logic [NB-1:0] p, int ptr);
      for (int o = 0; o < NB; o++)
         if (!p[(ptr + o) % NB]) return (ptr + o) % NB;
      return 0;
   endfunction

   task automatic chk(bit ok, string tag, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      int s = exp_sel(m_pend);
      bit f = &m_pend;
      chk(pend == m_pend, tag, "pending", int'(pend), int'(m_pend));
      chk(sel_vld == (s >= 0), tag, "sel_vld", int'(sel_vld), int'(s >= 0));
      if (s >= 0) chk(int'(sel_idx) == s, tag, "sel_idx", int'(sel_idx), s);
      chk(full == f, tag, "full", int'(full), int'(f));
      chk(int'(put_idx) == (f ? 0 : exp_put(m_pend, m_ptr)), tag, "put_idx",
          int'(put_idx), f ? 0 : exp_put(m_pend, m_ptr));
   endtask

   task automatic step(logic [NB-1:0] s, logic [NB-1:0] c, logic d, string tag);
      logic [NB-1:0] nxt;
      int sl = exp_sel(m_pend);
      int pu = exp_put(m_pend, m_ptr);
      req_set = s; cancel = c; done = d;
      nxt = (m_pend | s) & ~c;
      if (d && sl >= 0) nxt[sl] = 1'b0;
      if (!(&m_pend) && s[pu]) m_ptr = (pu + 1) % NB;
      @(posedge clk);
      @(negedge clk);
      m_pend = nxt;
      req_set = '0; cancel = '0; done = 1'b0;
      check_all(tag);
   endtask

   task automatic set_id(int i, bit x, int base, int low);
      bx[i] = x;
      if (x) bid[i] = {11'(base), 18'(low)};
      else   bid[i] = {18'($urandom), 11'(base)};
   endtask

   initial begin
      void'($urandom(32'h5eed_1234));
      for (int i = 0; i < NB; i++) bid[i] = '0;
      m_pend = '0; m_ptr = 0;
      repeat (3) @(negedge clk);
      check_all("R12");
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R12");

      // R2: standard base 3 beats extended base 5
      set_id(0, 1, 5, 0); set_id(1, 0, 3, 0); set_id(2, 0, 7, 0);
      step(3'b001, '0, 0, "R10");
      step(3'b110, '0, 0, "R2");
      chk(full, "R9", "full when all pending", int'(full), 1);
      step('0, '0, 1, "R8");
      chk(!full, "R11", "full after done", int'(full), 0);
      step(3'b010, '0, 0, "R9");
      step('0, 3'b100, 0, "R11");
      step('0, 3'b111, 0, "R7");
      step('0, '0, 1, "R8");
      step(3'b011, 3'b001, 0, "R7");
      // R3: equal base, standard wins
      set_id(0, 1, 3, 0); set_id(1, 0, 3, 0);
      step(3'b001, '0, 0, "R3");
      // R4: extended against extended on low bits
      set_id(0, 1, 9, 5); set_id(2, 1, 9, 2); set_id(1, 0, 20, 0);
      step(3'b101, '0, 0, "R4");
      // R5: identical identifiers pick lowest number
      set_id(0, 0, 4, 0); set_id(1, 0, 4, 0); set_id(2, 0, 4, 0);
      step(3'b111, '0, 0, "R5");
      step(3'b111, '0, 0, "R6");
      step('0, '0, 1, "R5");
      step('0, '0, 1, "R5");
      step('0, '0, 1, "R8");
      // R10: fill via put index only
      for (int k = 0; k < 4; k++) begin
         logic [NB-1:0] v = '0;
         v[put_idx] = 1'b1;
         step(v, '0, 0, "R10");
         if (k == 1) step('0, 3'b001, 0, "R10");
      end

      for (int n = 0; n < 3000; n++) begin
         for (int i = 0; i < NB; i++)
            if ($urandom_range(0, 7) == 0)
               set_id(i, 1'($urandom), $urandom_range(0, 3), $urandom_range(0, 2));
         step(NB'($urandom) & NB'($urandom), ($urandom_range(0, 3) == 0) ? NB'($urandom) : '0,
              1'($urandom_range(0, 2) == 0), "R1");
      end

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #1500000;
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule